// File: doc/BRIEF.md
# Add/Subtract Unit with Conditional Status Flags

This block adds or subtracts two operands and keeps a four-bit status register. The four flags are Negative, Zero, Carry and Overflow. Each operation is presented for one cycle with a valid strobe. The operation code chooses one of three functions: plain add, subtract, or add-with-carry, which takes its carry-in from the stored Carry flag. A set-flags control bit decides whether this operation rewrites the status register or leaves it exactly as it was.

The result is always written on a valid operation. The flags are written only when set-flags is high, so a caller can run address or counter arithmetic without disturbing a condition it set up earlier.

Carry is found by comparing the truncated result with the exact unsigned sum. Overflow is found by comparing the truncated result with the exact signed sum. Both sums include the carry-in.

Top module: `addsub_flags`

## Requirements
- R1: With op code 0 (add) and in_valid high, the next res_q is the low W bits of opa + opb with a carry-in of 0.
- R2: With op code 1 (subtract), the next res_q is the low W bits of opa + ~opb + 1. Carry is then 1 exactly when opa >= opb unsigned, which means no borrow occurred.
- R3: With op code 2 (add-with-carry), the next res_q is the low W bits of opa + opb + C. C is the Carry flag held before this operation.
- R4: Op code 3 behaves exactly as op code 0.
- R5: On a flag-setting operation, the new Carry (flags_q[1]) is 0 when the W-bit result read as unsigned equals the full unsigned sum including carry-in, and 1 otherwise.
- R6: On a flag-setting operation, the new Overflow (flags_q[0]) is 0 when the W-bit result read as signed equals the full signed sum including carry-in, and 1 otherwise.
- R7: On a flag-setting operation, Negative (flags_q[3]) becomes result bit W-1, and Zero (flags_q[2]) becomes 1 exactly when all result bits are 0.
- R8: A valid operation with set_flags low writes res_q but leaves all four flags unchanged.
- R9: While in_valid is low, res_q and flags_q hold their values and res_valid is 0.
- R10: A synchronous active-high reset clears res_q, flags_q and res_valid to 0.
- R11: res_q, flags_q and res_valid change on the clock edge that samples in_valid high. res_valid is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 0 add, 1 subtract, 2 add-with-carry, 3 same as add |
| set_flags | input | 1 | 1: this operation updates the flags |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| res_q | output | W | Registered result |
| res_valid | output | 1 | High for one cycle after a valid operation |
| flags_q | output | 4 | Status register {N, Z, C, V} |

## Verification
The bench drives several boundary cases:
- Subtractions with equal operands and with a smaller minuend. A design that inverted the borrow sense would report Carry backwards.
- Sums across the signed limits, such as 0x7FFFFFFF + 1 and 0x80000000 + 0x80000000. A design that derived Overflow from the unsigned carry would flag the wrong cases.
- Chained add-with-carry operations. These show whether the stored Carry, not a fresh zero, feeds the next operation.
- Operations with set_flags low placed between flag-setting ones. These catch a status register that is written unconditionally.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_ADC  = 2'd2,
    OP_ADD2 = 2'd3
  } op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int NFLAGS = 4;
endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int W = 32
) (
  input  logic [1:0]   op_sel,
  input  logic         c_stored,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         cin
);
  import addsub_pkg::*;

  always_comb begin
    b_out = b_in;
    cin   = 1'b0;
    unique case (op_e'(op_sel))
      OP_SUB: begin
        b_out = ~b_in;
        cin   = 1'b1;
      end
      OP_ADC:  cin = c_stored;
      default: cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int UW = W + 1;
  localparam int SW = W + 2;

  logic [UW-1:0]        usum;
  logic signed [SW-1:0] ssum;
  logic signed [SW-1:0] sres;

  always_comb begin
    usum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    ssum  = $signed({{2{x[W-1]}}, x}) + $signed({{2{y[W-1]}}, y})
          + $signed({{(SW-1){1'b0}}, cin});
    sum   = usum[W-1:0];
    sres  = $signed({{2{sum[W-1]}}, sum});
    carry = (usum != {1'b0, sum});
    ovf   = (ssum != sres);
  end
endmodule

// File: rtl/addsub_nz.sv
module addsub_nz #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic         zero
);
  assign neg  = val[W-1];
  assign zero = ~|val;
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   op_sel,
  input  logic         set_flags,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res_q,
  output logic         res_valid,
  output logic [3:0]   flags_q
);
  import addsub_pkg::*;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] sum;
  logic         c_new, v_new, n_new, z_new;
  logic [NFLAGS-1:0] flags_next;

  addsub_operand #(.W(W)) u_opnd (
    .op_sel   (op_sel),
    .c_stored (flags_q[FLAG_C]),
    .b_in     (opb),
    .b_out    (b_eff),
    .cin      (cin)
  );

  addsub_core #(.W(W)) u_core (
    .x     (opa),
    .y     (b_eff),
    .cin   (cin),
    .sum   (sum),
    .carry (c_new),
    .ovf   (v_new)
  );

  addsub_nz #(.W(W)) u_nz (
    .val  (sum),
    .neg  (n_new),
    .zero (z_new)
  );

  always_comb begin
    flags_next         = '0;
    flags_next[FLAG_N] = n_new;
    flags_next[FLAG_Z] = z_new;
    flags_next[FLAG_C] = c_new;
    flags_next[FLAG_V] = v_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      res_valid <= 1'b0;
      flags_q   <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_q <= sum;
      if (in_valid && set_flags) flags_q <= flags_next;
    end
  end
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   op_sel,
  input logic         set_flags,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] res_q,
  input logic         res_valid,
  input logic [3:0]   flags_q
);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_q == 4'd0 && res_q == '0 && !res_valid));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && set_flags) |=> $stable(flags_q));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && set_flags) |=> (flags_q[2] == (res_q == '0)));

  // R7
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && set_flags) |=> (flags_q[3] == res_q[W-1]));

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'd0) |=> (res_q == $past(opa) + $past(opb)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_q) && !res_valid));

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
endmodule

bind addsub_flags addsub_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
  .set_flags(set_flags), .opa(opa), .opb(opb), .res_q(res_q),
  .res_valid(res_valid), .flags_q(flags_q)
);

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   op_sel;
  logic         set_flags;
  logic [W-1:0] opa, opb;
  logic [W-1:0] res_q;
  logic         res_valid;
  logic [3:0]   flags_q;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] exp_flags;
  logic [W-1:0] exp_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_flags #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .set_flags(set_flags), .opa(opa), .opb(opb), .res_q(res_q),
    .res_valid(res_valid), .flags_q(flags_q)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected result and flags from the arithmetic definitions.
  task automatic model(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic cflag,
                       output logic [W-1:0] r, output logic [3:0] f);
    logic [W-1:0] y;
    logic cin;
    longint unsigned us;
    longint signed ss;
    longint signed sr;
    y   = (op == 2'd1) ? ~b : b;
    cin = (op == 2'd1) ? 1'b1 : ((op == 2'd2) ? cflag : 1'b0);
    us  = longint'(a) + longint'(y) + longint'(cin);
    ss  = longint'($signed(a)) + longint'($signed(y)) + longint'(cin);
    r   = us[W-1:0];
    sr  = longint'($signed(r));
    f[3] = r[W-1];
    f[2] = (r == '0);
    f[1] = (us != longint'(r));
    f[0] = (ss != sr);
  endtask

  task automatic do_op(input string req, input logic [1:0] op,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sf);
    logic [3:0] f;
    model(op, a, b, exp_flags[1], exp_res, f);
    if (sf) exp_flags = f;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opa = a; opb = b; set_flags = sf;
    @(negedge clk);
    in_valid = 1'b0; opa = '0; opb = '0;
    check(req, "result", res_q, exp_res);
    check(req, "flags", {28'd0, flags_q}, {28'd0, exp_flags});
    check("R11", "res_valid", {31'd0, res_valid}, 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; op_sel = 2'd0; set_flags = 1'b0;
    opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    check("R10", "res_q", res_q, '0);
    check("R10", "flags", {28'd0, flags_q}, 32'd0);
    check("R10", "res_valid", {31'd0, res_valid}, 32'd0);
    rst = 1'b0;
    exp_flags = 4'd0;
    exp_res   = '0;
  endtask

  task automatic t_add();
    do_op("R1", 2'd0, 32'h0000_1234, 32'h0000_0011, 1'b1);
    do_op("R7", 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1); // Z=1, C=1
    do_op("R6", 2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1); // N=1, V=1
    do_op("R5", 2'd0, 32'h8000_0000, 32'h8000_0000, 1'b1); // Z,C,V
  endtask

  task automatic t_sub();
    do_op("R2", 2'd1, 32'd5, 32'd5, 1'b1);   // no borrow, zero
    do_op("R2", 2'd1, 32'd3, 32'd7, 1'b1);   // borrow, C=0
    do_op("R6", 2'd1, 32'h8000_0000, 32'd1, 1'b1); // signed overflow
    do_op("R5", 2'd1, 32'd9, 32'd2, 1'b1);
  endtask

  task automatic t_adc();
    do_op("R3", 2'd0, 32'hFFFF_FFFF, 32'h0000_0002, 1'b1); // sets C
    do_op("R3", 2'd2, 32'h0000_0010, 32'h0000_0020, 1'b1); // uses C=1
    do_op("R3", 2'd2, 32'h0000_0010, 32'h0000_0020, 1'b1); // uses C=0
    do_op("R3", 2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
  endtask

  task automatic t_op3();
    do_op("R1", 2'd1, 32'd4, 32'd1, 1'b1);   // C=1 stored
    do_op("R4", 2'd3, 32'h0000_0100, 32'h0000_0001, 1'b1); // no carry-in
  endtask

  task automatic t_noflags();
    do_op("R8", 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    do_op("R8", 2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    do_op("R8", 2'd1, 32'd1, 32'd2, 1'b0);
    do_op("R8", 2'd2, 32'd1, 32'd1, 1'b0); // carry-in from held C=1
  endtask

  task automatic t_idle();
    logic [W-1:0] r0;
    logic [3:0] f0;
    r0 = res_q; f0 = flags_q;
    @(negedge clk);
    in_valid = 1'b0; set_flags = 1'b1; op_sel = 2'd1;
    opa = 32'hDEAD_BEEF; opb = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R9", "res_q hold", res_q, r0);
    check("R9", "flags hold", {28'd0, flags_q}, {28'd0, f0});
    check("R9", "res_valid low", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_sweep();
    logic [W-1:0] a, b;
    a = 32'h1357_9BDF; b = 32'h0F0F_F0F0;
    for (int i = 0; i < 40; i++) begin
      do_op("R5", 2'(i % 3), a, b, 1'(i % 4 != 3));
      a = a * 32'd1103515245 + 32'd12345;
      b = (b << 3) ^ (b >> 5) ^ a;
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_adc();
    t_op3();
    t_noflags();
    t_idle();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule